// File: doc/BRIEF.md
# Iterative CORDIC Rotation and Vectoring Engine

This block computes circular CORDIC in either of its two classic directions with a single shift-add micro-rotation stage. The stage is reused once per clock for a fixed number of iterations. A caller presents signed X, Y and Z operands and a mode bit, then pulses a load strobe. The engine raises a busy flag while it iterates. When the last micro-rotation lands in a set of result registers, it pulses a one-cycle result-valid flag.

Z is an angle in binary radians: a full turn equals 2^DATA_W units, so Z arithmetic simply wraps. In rotation mode the engine steers the residual angle toward zero, which turns the (X, Y) vector by Z0. In vectoring mode it steers Y toward zero, which leaves the vector's angle added to Z0 and the vector's length in X. In both modes X and Y come out scaled by the CORDIC gain, about 1.647 for long runs. Z is never scaled. The arctangent constants are computed at elaboration for any operand width and iteration count.

Gain compensation is left to the caller, and so are headroom in X and Y and folding operands into the convergent half-plane.

Top module: `cordic_iter_engine`

## Requirements
- R1: `modeIn` is sampled only in the cycle a load is accepted and governs that whole computation. The encoding is 0 = rotation and 1 = vectoring, and changes to `modeIn` while busy have no effect.
- R2: In rotation mode, with |Z0| at most a quarter turn (2^(DATA_W-2) brads), the results are X ≈ K·(X0·cos θ − Y0·sin θ) and Y ≈ K·(X0·sin θ + Y0·cos θ). Here θ is the angle actually turned and K = Π sqrt(1+2^-2i) over the iterations. Z ends within a few brads of zero.
- R3: In vectoring mode with X0 > 0, X ends ≈ K·sqrt(X0²+Y0²), Y ends ≈ 0, and Z ends ≈ Z0 + atan2(Y0, X0) expressed in brads.
- R4: A load is accepted only while `busy` is low. A load pulse during busy is ignored: it neither restarts the count nor alters the operands or the result.
- R5: `busy` rises in the cycle after an accepted load and stays high for exactly ITER_CNT cycles. `resultValid` is high for exactly one cycle, the cycle in which `busy` has just fallen.
- R6: `xOut`, `yOut` and `zOut` change only at the edge that raises `resultValid`, and they hold their values through later idle and busy cycles.
- R7: Z arithmetic is modulo 2^DATA_W. An accumulated angle that passes the half-turn point wraps to the negative side with no saturation.
- R8: The reset is asynchronous and active at level RST_ACTIVE (default 0). While it is asserted, `busy`, `resultValid` and all three outputs are zero, even without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstIn | input | 1 | Asynchronous reset, active at RST_ACTIVE |
| loadIn | input | 1 | Start strobe; captures operands and mode when idle |
| modeIn | input | 1 | 0 = rotation, 1 = vectoring |
| xIn | input | DATA_W | Initial X, signed |
| yIn | input | DATA_W | Initial Y, signed |
| zIn | input | DATA_W | Initial angle in brads |
| busy | output | 1 | High while iterations run |
| resultValid | output | 1 | One-cycle pulse when results update |
| xOut | output | DATA_W | Final X, signed |
| yOut | output | DATA_W | Final Y, signed |
| zOut | output | DATA_W | Final angle in brads |

## Verification
The bench sweeps the rotation angle across the whole ±quarter-turn range and sweeps a grid of first- and fourth-quadrant vectors in vectoring mode, comparing every result against trigonometry computed in the bench with a tolerance. A wrong micro-rotation direction or a wrong arctangent constant throws those results far off. A load and a mode flip are injected mid-run, and a design that honoured them would restart, stretch the latency count or return a vectoring answer to a rotation request. Vectoring runs started near the half-turn boundary catch a Z path that saturates or sign-extends instead of wrapping. Outputs are compared against the previous result during busy, which exposes a design that shows its working registers at the ports. A reset asserted between clock edges checks that the clear does not wait for a clock.

// File: rtl/cordic_iter_pkg.sv
package cordic_iter_pkg;

  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_VECTOR = 1'b1
  } cordicMode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;  // capture operands and mode
    logic step;  // apply one micro-rotation
    logic last;  // this step is the final one; latch results
  } seqStrobe_t;

  // atan(2^-idx) in brads for a turn of 2^width units, rounded to nearest.
  function automatic longint atanBrad(input int idx, input int width);
    real turn;
    real ang;
    turn = 2.0 ** width;
    ang  = $atan(2.0 ** (-idx));
    return longint'(ang * turn / (2.0 * 3.14159265358979323846));
  endfunction

endpackage

// File: rtl/cordic_iter_seq.sv
module cordic_iter_seq
  import cordic_iter_pkg::*;
#(
  parameter int ITER_CNT = 10,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             loadIn,
  output logic             busy,
  output logic             resultValid,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] iterIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ITER_CNT - 1);

  seqState_e state;
  logic      atLast;

  assign atLast = (iterIdx == LAST_IDX);
  assign busy   = (state == ST_RUN);

  always_comb begin
    strobe      = '0;
    strobe.load = (state == ST_IDLE) && loadIn;
    strobe.step = (state == ST_RUN);
    strobe.last = (state == ST_RUN) && atLast;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      state       <= ST_IDLE;
      iterIdx     <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          iterIdx <= '0;
          if (loadIn) state <= ST_RUN;
        end
        ST_RUN: begin
          if (atLast) begin
            state       <= ST_IDLE;
            iterIdx     <= '0;
            resultValid <= 1'b1;
          end else begin
            iterIdx <= iterIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (arst)
    (loadIn && !busy) |=> busy); // R5

  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (arst)
    (busy && !atLast) |=> (busy && iterIdx == $past(iterIdx) + 1'b1)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (arst)
    resultValid |=> !resultValid); // R5

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (arst)
    resultValid |-> (!busy && $past(busy))); // R5

endmodule

// File: rtl/cordic_iter_dp.sv
module cordic_iter_dp
  import cordic_iter_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ITER_CNT = 10,
  parameter int IDX_W    = 4
) (
  input  logic                     clk,
  input  logic                     arst,
  input  seqStrobe_t               strobe,
  input  logic [IDX_W-1:0]         iterIdx,
  input  logic                     modeIn,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] yIn,
  input  logic signed [DATA_W-1:0] zIn,
  output logic signed [DATA_W-1:0] xRes,
  output logic signed [DATA_W-1:0] yRes,
  output logic signed [DATA_W-1:0] zRes
);

  // Arctangent constants, one per iteration, built at elaboration.
  logic signed [DATA_W-1:0] angTab [ITER_CNT];

  for (genvar g = 0; g < ITER_CNT; g++) begin : g_ang
    assign angTab[g] = DATA_W'(atanBrad(g, DATA_W));
  end

  cordicMode_e              modeReg;
  logic signed [DATA_W-1:0] xCur, yCur, zCur;
  logic signed [DATA_W-1:0] xShift, yShift, angStep;
  logic signed [DATA_W-1:0] xNext, yNext, zNext;
  logic                     turnCcw;

  // One micro-rotation; the Z sum wraps modulo 2^DATA_W by width.
  always_comb begin
    xShift  = xCur >>> iterIdx;
    yShift  = yCur >>> iterIdx;
    angStep = angTab[iterIdx];
    if (modeReg == MODE_VECTOR) turnCcw = yCur[DATA_W-1];
    else                        turnCcw = !zCur[DATA_W-1];
    if (turnCcw) begin
      xNext = xCur - yShift;
      yNext = yCur + xShift;
      zNext = zCur - angStep;
    end else begin
      xNext = xCur + yShift;
      yNext = yCur - xShift;
      zNext = zCur + angStep;
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      modeReg <= MODE_ROTATE;
      xCur    <= '0;
      yCur    <= '0;
      zCur    <= '0;
    end else if (strobe.load) begin
      modeReg <= cordicMode_e'(modeIn);
      xCur    <= xIn;
      yCur    <= yIn;
      zCur    <= zIn;
    end else if (strobe.step) begin
      xCur <= xNext;
      yCur <= yNext;
      zCur <= zNext;
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      xRes <= '0;
      yRes <= '0;
      zRes <= '0;
    end else if (strobe.last) begin
      xRes <= xNext;
      yRes <= yNext;
      zRes <= zNext;
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (arst)
    strobe.step |=> $stable(modeReg)); // R1

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (arst)
    !strobe.last |=> ($stable(xRes) && $stable(yRes) && $stable(zRes))); // R6

  AST_LOAD_NOT_WHILE_STEP: assert property (@(posedge clk) disable iff (arst)
    !(strobe.load && strobe.step)); // R4

endmodule

// File: rtl/cordic_iter_engine.sv
module cordic_iter_engine
  import cordic_iter_pkg::*;
#(
  parameter int   DATA_W     = 12,
  parameter int   ITER_CNT   = 10,
  parameter logic RST_ACTIVE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstIn,
  input  logic                     loadIn,
  input  logic                     modeIn,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] yIn,
  input  logic signed [DATA_W-1:0] zIn,
  output logic                     busy,
  output logic                     resultValid,
  output logic signed [DATA_W-1:0] xOut,
  output logic signed [DATA_W-1:0] yOut,
  output logic signed [DATA_W-1:0] zOut
);

  localparam int IDX_W = (ITER_CNT > 1) ? $clog2(ITER_CNT) : 1;

  logic             arst;
  seqStrobe_t       strobe;
  logic [IDX_W-1:0] iterIdx;

  assign arst = (rstIn == RST_ACTIVE);

  cordic_iter_seq #(
    .ITER_CNT (ITER_CNT),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk         (clk),
    .arst        (arst),
    .loadIn      (loadIn),
    .busy        (busy),
    .resultValid (resultValid),
    .strobe      (strobe),
    .iterIdx     (iterIdx)
  );

  cordic_iter_dp #(
    .DATA_W   (DATA_W),
    .ITER_CNT (ITER_CNT),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk     (clk),
    .arst    (arst),
    .strobe  (strobe),
    .iterIdx (iterIdx),
    .modeIn  (modeIn),
    .xIn     (xIn),
    .yIn     (yIn),
    .zIn     (zIn),
    .xRes    (xOut),
    .yRes    (yOut),
    .zRes    (zOut)
  );

endmodule

// File: tb/cordic_iter_engine_tb.sv
module cordic_iter_engine_tb;

  localparam int  W     = 12;
  localparam int  N     = 10;
  localparam int  TURN  = 1 << W;
  localparam real PI    = 3.14159265358979323846;
  localparam real TOLXY = 20.0;
  localparam int  TOLZ  = 6;

  logic clk = 1'b0;
  logic rstIn = 1'b0;
  logic loadIn = 1'b0;
  logic modeIn = 1'b0;
  logic signed [W-1:0] xIn = '0, yIn = '0, zIn = '0;
  logic busy, resultValid;
  logic signed [W-1:0] xOut, yOut, zOut;

  int  nChecks = 0;
  int  nFails  = 0;
  int  cycles  = 0;
  int  prevX = 0, prevY = 0, prevZ = 0;
  int  lastCyc;
  real gainK;

  always #4 clk = ~clk;

  cordic_iter_engine #(.DATA_W(W), .ITER_CNT(N), .RST_ACTIVE(1'b0)) u_dut (
    .clk(clk), .rstIn(rstIn), .loadIn(loadIn), .modeIn(modeIn),
    .xIn(xIn), .yIn(yIn), .zIn(zIn), .busy(busy), .resultValid(resultValid),
    .xOut(xOut), .yOut(yOut), .zOut(zOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      nFails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 200000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(input string tag, input int act, input real exp, input real tol);
    real d;
    nChecks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0.2f (tol %0.1f)", tag, act, exp, tol);
    end
  endtask

  // Compare brad angles modulo one turn.
  task automatic checkAngle(input string tag, input int act, input real exp, input int tol);
    int e, d;
    nChecks++;
    e = int'(exp);
    d = (((act - e) % TURN) + TURN + TURN / 2) % TURN - TURN / 2;
    if (d > tol || d < -tol) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (mod %0d, tol %0d)", tag, act, e, TURN, tol);
    end
  endtask

  // Start one computation; optionally inject a load plus mode flip at busy cycle dAt.
  task automatic runOp(input logic m, input int x0, input int y0, input int z0, input int dAt);
    int cyc;
    @(negedge clk);
    loadIn = 1'b1; modeIn = m;
    xIn = W'(x0); yIn = W'(y0); zIn = W'(z0);
    @(negedge clk);
    loadIn = 1'b0;
    checkEq("R5 busy after load", int'(busy), 1);
    // R6: outputs still show the previous result while busy
    checkEq("R6 hold during busy x", int'(xOut), prevX);
    cyc = 0;
    while (!resultValid && cyc < 4 * N) begin
      if (cyc == dAt) begin
        loadIn = 1'b1; modeIn = ~m;
        xIn = W'(123); yIn = W'(-321); zIn = W'(777);
      end else begin
        loadIn = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    loadIn = 1'b0;
    lastCyc = cyc;
    checkEq("R5 latency", cyc, N);
    checkEq("R5 busy low with valid", int'(busy), 0);
    prevX = int'(xOut); prevY = int'(yOut); prevZ = int'(zOut);
    @(negedge clk);
    checkEq("R5 valid one cycle", int'(resultValid), 0);
  endtask

  task automatic checkRotate(input int x0, input int y0, input int z0);
    real th;
    runOp(1'b0, x0, y0, z0, -1);
    th = real'(z0 - prevZ) * 2.0 * PI / real'(TURN);
    checkNear("R2 rotate x", prevX, gainK * (x0 * $cos(th) - y0 * $sin(th)), TOLXY);
    checkNear("R2 rotate y", prevY, gainK * (x0 * $sin(th) + y0 * $cos(th)), TOLXY);
    checkAngle("R2 rotate z residual", prevZ, 0.0, TOLZ);
  endtask

  task automatic checkVector(input int x0, input int y0, input int z0, input string tag);
    real mag, ang;
    runOp(1'b1, x0, y0, z0, -1);
    mag = $sqrt(real'(x0) * x0 + real'(y0) * y0);
    ang = real'(z0) + $atan2(real'(y0), real'(x0)) * real'(TURN) / (2.0 * PI);
    checkNear({tag, " vector x"}, prevX, gainK * mag, TOLXY);
    checkNear({tag, " vector y"}, prevY, 0.0, 12.0);
    checkAngle({tag, " vector z"}, prevZ, ang, TOLZ);
  endtask

  initial begin
    int hx, hy, hz;
    real th;
    gainK = 1.0;
    for (int i = 0; i < N; i++) gainK = gainK * $sqrt(1.0 + 2.0 ** (-2 * i));

    // R8: reset state
    rstIn = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R8 reset busy", int'(busy), 0);
    checkEq("R8 reset valid", int'(resultValid), 0);
    checkEq("R8 reset x", int'(xOut), 0);
    checkEq("R8 reset z", int'(zOut), 0);
    rstIn = 1'b1;
    @(negedge clk);

    // R2: rotation sweep over the full quarter-turn range
    for (int z = -(TURN / 4); z <= TURN / 4; z += 16) checkRotate(900, 0, z);
    for (int z = -(TURN / 4); z <= TURN / 4; z += 64) checkRotate(600, -500, z);

    // R3: vectoring grid in the right half-plane
    for (int xv = 400; xv <= 1000; xv += 300) begin
      for (int yv = -1000; yv <= 1000; yv += 100) begin
        if (xv * xv + yv * yv <= 1200 * 1200) checkVector(xv, yv, 0, "R3");
      end
    end

    // R7: angle accumulation crossing the half-turn point wraps
    checkVector(800, 600, 2000, "R7");
    checkVector(700, -700, -2000, "R7");
    checkEq("R7 wrapped sign", int'(prevZ < 0 ? 0 : 1), 1);

    // R4 and R1: load and mode flip while busy are ignored
    runOp(1'b0, 900, 0, 300, 3);
    checkEq("R4 no restart", lastCyc, N);
    th = real'(300 - prevZ) * 2.0 * PI / real'(TURN);
    checkNear("R4 R1 x unaffected", prevX, gainK * 900.0 * $cos(th), TOLXY);
    checkNear("R4 R1 y unaffected", prevY, gainK * 900.0 * $sin(th), TOLXY);
    checkAngle("R1 rotation kept", prevZ, 0.0, TOLZ);

    // R6: outputs hold while idle with changing inputs and no load
    hx = int'(xOut); hy = int'(yOut); hz = int'(zOut);
    for (int k = 0; k < 4; k++) begin
      xIn = W'(k * 111); yIn = W'(-k * 57); zIn = W'(k * 300); modeIn = k[0];
      @(negedge clk);
    end
    checkEq("R6 idle hold x", int'(xOut), hx);
    checkEq("R6 idle hold y", int'(yOut), hy);
    checkEq("R6 idle hold z", int'(zOut), hz);

    // R8: asynchronous reset in mid-run, observed between edges
    @(negedge clk);
    loadIn = 1'b1; modeIn = 1'b1; xIn = W'(500); yIn = W'(300); zIn = W'(0);
    @(negedge clk);
    loadIn = 1'b0;
    repeat (3) @(negedge clk);
    #1 rstIn = 1'b0;
    #1;
    checkEq("R8 async busy clear", int'(busy), 0);
    checkEq("R8 async x clear", int'(xOut), 0);
    checkEq("R8 async y clear", int'(yOut), 0);
    @(negedge clk);
    rstIn = 1'b1;
    prevX = 0; prevY = 0; prevZ = 0;

    // R1: same operands after reset, vectoring mode selected
    checkVector(500, 300, 0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule